// File: doc/BRIEF.md
# Carrier-Locked PWM Duty Counter

This block is the duty-tracking counter of one inverter phase. A separate master timer runs the triangular carrier. It tells this counter which way to count and when a carrier period ends. After a start strobe, the counter takes its duty value from a buffered data register on the next count tick. From then on it counts up or down in step with the master.

On every tick that leaves the counter at 1, the block emits a single-cycle match pulse. The pulse carries a tag giving the direction of that tick. Because the counter follows the master's direction, one match lands in the falling half of the triangle and one in the rising half. The output stage uses the tag to tell them apart.

Writes to the duty register are held in a buffer. They take effect only at a reload point. A reload happens on the first tick after start, and on any tick where the master's period event arrives while the master counts up. A start strobe sent to a channel that is already running is rejected and sets a sticky error flag.

Top module: `tri_duty_counter`

## Requirements
- R1: A synchronous active-high `rst` sets `cnt`, the duty buffer, `active`, `cnt_up`, `dmatch`, `dmatch_up` and `start_err` to 0.
- R2: A `start` pulse while `active` is 0 sets `active` to 1 but leaves `cnt` as it is. The first `tick` after that loads `cnt` from the duty buffer.
- R3: On a `tick` while active with no reload, `cnt` goes up by 1 if `mst_up` is 1 and down by 1 if `mst_up` is 0, wrapping modulo 2^W. Without a `tick`, `cnt` holds.
- R4: `dmatch` is high for exactly the one cycle after a tick (count or load) that leaves `cnt` equal to 1. During that cycle `dmatch_up` holds the `mst_up` value of that tick (1 = up, 0 = down).
- R5: A tick with `mst_prd`=1 and `mst_up`=1 loads `cnt` from the duty buffer. If `mst_prd` arrives with `mst_up`=0, or without a tick, it has no effect beyond normal counting.
- R6: `cnt_up` holds the `mst_up` value of the most recent tick taken while active.
- R7: A `start` pulse while `active` is 1 leaves the count sequence unchanged and sets `start_err`. `start_err` stays set until reset.
- R8: `duty_wr` stores `duty_wdata` in the buffer, and `cnt` changes only at the next reload point. A write in the same cycle as a reload takes effect at the reload after that.
- R9: While `active` is 0, ticks leave `cnt` at 0 and `dmatch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count clock enable |
| start | input | 1 | Channel start strobe |
| mst_up | input | 1 | Master direction, 1 = counting up |
| mst_prd | input | 1 | Master carrier period event |
| duty_wr | input | 1 | Duty buffer write strobe |
| duty_wdata | input | W | Duty value to buffer |
| cnt | output | W | Current count |
| cnt_up | output | 1 | Direction status of the last tick |
| active | output | 1 | Channel running |
| dmatch | output | 1 | Duty match pulse |
| dmatch_up | output | 1 | Direction tag of the match pulse |
| start_err | output | 1 | Sticky flag for an illegal restart |

## Verification
A missed reload or a wrong direction step shows on `cnt` at the next sampling point. The same fault moves the match pulse to another tick, or drops it, within one carrier half. If the buffer leaks a write early, the count jumps in a cycle with no reload condition. A wrong direction tag disagrees with `cnt_up` in the same cycle as the pulse. A rejected restart that corrupts state shows as a count off the expected ramp on the very next tick.

// File: rtl/tri_duty_counter.sv
module tri_duty_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic         mst_up,
  input  logic         mst_prd,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_wdata,
  output logic [W-1:0] cnt,
  output logic         cnt_up,
  output logic         active,
  output logic         dmatch,
  output logic         dmatch_up,
  output logic         start_err
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] dbuf;
  logic         pend;

  wire         step   = active && tick;
  wire         reload = pend || (mst_prd && mst_up);
  wire [W-1:0] nxt    = reload ? dbuf : (mst_up ? cnt + ONE : cnt - ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      dbuf      <= '0;
      pend      <= 1'b0;
      active    <= 1'b0;
      cnt_up    <= 1'b0;
      dmatch    <= 1'b0;
      dmatch_up <= 1'b0;
      start_err <= 1'b0;
    end else begin
      dmatch <= 1'b0;
      if (duty_wr) dbuf <= duty_wdata;
      if (start) begin
        if (active) start_err <= 1'b1;
        else begin
          active <= 1'b1;
          pend   <= 1'b1;
        end
      end
      if (step) begin
        cnt       <= nxt;
        cnt_up    <= mst_up;
        pend      <= 1'b0;
        dmatch    <= (nxt == ONE);
        dmatch_up <= mst_up;
      end
    end
  end
endmodule

module tri_duty_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         start,
  input logic         mst_up,
  input logic         mst_prd,
  input logic         duty_wr,
  input logic [W-1:0] duty_wdata,
  input logic [W-1:0] cnt,
  input logic         cnt_up,
  input logic         active,
  input logic         dmatch,
  input logic         dmatch_up,
  input logic         start_err
);
  AST_MATCH_AT_ONE: assert property (@(posedge clk) disable iff (rst) dmatch |-> cnt == W'(1)); // R4
  AST_MATCH_TAG:    assert property (@(posedge clk) disable iff (rst) dmatch |-> dmatch_up == cnt_up); // R4
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst) !tick |=> $stable(cnt)); // R3
  AST_ACTIVE_STAYS: assert property (@(posedge clk) disable iff (rst) active |=> active); // R2
  AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (rst) start_err |=> start_err); // R7
  AST_IDLE_ZERO:    assert property (@(posedge clk) disable iff (rst) !active |-> (cnt == '0 && !dmatch)); // R9
endmodule

bind tri_duty_counter tri_duty_counter_chk #(.W(W)) u_chk (.*);

// File: tb/tri_duty_counter_bench.sv
`timescale 1ns/1ps
module tri_duty_counter_bench;
  logic clk = 0, rst = 1, tick = 0, start = 0, mst_up = 0, mst_prd = 0, duty_wr = 0;
  logic [15:0] duty_wdata = '0;
  logic [15:0] cnt;
  logic cnt_up, active, dmatch, dmatch_up, start_err;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  tri_duty_counter #(.W(16)) u_tri_duty_counter (.*);

  // {tick,start,up,prd,wr, wdata, exp_cnt, exp_match, exp_mdir, exp_dir}
  localparam int N = 17;
  localparam logic [39:0] VEC [N] = '{
    {5'b10001, 16'd3, 16'd0, 3'b000},  // R9 tick while idle, R8 write buffered
    {5'b01000, 16'd0, 16'd0, 3'b000},  // R2 start, no load yet
    {5'b10100, 16'd0, 16'd3, 3'b001},  // R2 first tick loads
    {5'b10000, 16'd0, 16'd2, 3'b000},
    {5'b10000, 16'd0, 16'd1, 3'b100},  // R4 down match
    {5'b00000, 16'd0, 16'd1, 3'b000},  // R3 hold, R4 single pulse
    {5'b10000, 16'd0, 16'd0, 3'b000},
    {5'b10100, 16'd0, 16'd1, 3'b111},  // R4 up match
    {5'b10100, 16'd0, 16'd2, 3'b001},
    {5'b10101, 16'd5, 16'd3, 3'b001},  // R8 write does not load
    {5'b10110, 16'd0, 16'd5, 3'b001},  // R5 reload in up phase
    {5'b10000, 16'd0, 16'd4, 3'b000},
    {5'b10010, 16'd0, 16'd3, 3'b000},  // R5 period in down phase ignored
    {5'b00110, 16'd0, 16'd3, 3'b000},  // R5 period without tick ignored
    {5'b10111, 16'd9, 16'd5, 3'b001},  // R8 same-cycle write uses old value
    {5'b10110, 16'd0, 16'd9, 3'b001},  // R8 new value at next reload
    {5'b10000, 16'd0, 16'd8, 3'b000}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic t, s, u, p, w, input logic [15:0] wd);
    @(negedge clk);
    tick = t; start = s; mst_up = u; mst_prd = p; duty_wr = w; duty_wdata = wd;
    @(negedge clk);
    tick = 0; start = 0; mst_prd = 0; duty_wr = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    tests++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk(cnt == 0 && !active && !start_err && !dmatch && !cnt_up, "R1 reset state", int'(cnt), 0);

    for (int i = 0; i < N; i++) begin
      drive(VEC[i][39], VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35], VEC[i][34:19]);
      chk(cnt == VEC[i][18:3], $sformatf("R3 cnt step %0d", i), int'(cnt), int'(VEC[i][18:3]));
      chk(dmatch == VEC[i][2], $sformatf("R4 match step %0d", i), int'(dmatch), int'(VEC[i][2]));
      if (VEC[i][2])
        chk(dmatch_up == VEC[i][1], $sformatf("R4 match tag step %0d", i), int'(dmatch_up), int'(VEC[i][1]));
      chk(cnt_up == VEC[i][0], $sformatf("R6 dir step %0d", i), int'(cnt_up), int'(VEC[i][0]));
    end

    // R7 restart while running
    chk(!start_err, "R7 no error before restart", int'(start_err), 0);
    drive(1, 1, 0, 0, 0, 16'd0);
    chk(cnt == 7, "R7 count unaffected by restart", int'(cnt), 7);
    chk(start_err && active, "R7 error flag set", int'(start_err), 1);
    drive(0, 0, 0, 0, 0, 16'd0);
    chk(start_err, "R7 error sticky", int'(start_err), 1);

    // R1 reset clears everything after activity
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk(cnt == 0 && !active && !start_err && !cnt_up, "R1 reset after run", int'(cnt) + int'(start_err), 0);

    // R2/R4 load landing on 1 matches; pulse lasts one cycle
    drive(0, 0, 0, 0, 1, 16'd1);
    drive(0, 1, 0, 0, 0, 16'd0);
    chk(active && cnt == 0, "R2 active after start", int'(active), 1);
    drive(1, 0, 1, 0, 0, 16'd0);
    chk(cnt == 1 && dmatch && dmatch_up, "R4 load to one matches up", int'(dmatch), 1);
    drive(0, 0, 1, 0, 0, 16'd0);
    chk(!dmatch && cnt == 1, "R4 pulse is one cycle", int'(dmatch), 0);
    // R3 wrap downward
    drive(1, 0, 0, 0, 0, 16'd0);
    drive(1, 0, 0, 0, 0, 16'd0);
    chk(cnt == 16'hFFFF, "R3 wrap below zero", int'(cnt), 65535);

    finish_run();
  end
endmodule